// File: doc/BRIEF.md
# Superscalar Bundle Issue Dependency Checker

This block sits at the issue stage of a dynamically scheduled superscalar core. Each cycle the decode stage presents a bundle of up to `LANES` decoded instructions. Every lane carries an operation class, an optional destination register and two source registers. The block picks the longest program-order prefix of the bundle that may issue. A lane stops the bundle when its class has already issued in this bundle, when the reservation station for its class is full, or when too few reorder-buffer entries remain. Each issued lane receives a fresh reorder-buffer tag. Each source operand receives the tag of its producer, or a ready flag when it has no producer still in flight.

Read-after-write dependences between lanes of the same bundle are resolved in the same cycle. A source that matches the destination of an older lane takes that lane's new tag, not the one in the register status table. After issue, the table maps every written register to the tag of its youngest writer in the bundle. A retire strobe frees the oldest reorder-buffer entry. It also clears any table entry that still points to that entry.

The bundle input is a valid/ready stream. `bnd_ready` is high only when every lane up to the first invalid lane has issued, so the whole bundle is consumed. When `bnd_ready` is low, `issue_mask` shows which prefix was taken. In the next cycle the upstream stage must present the bundle again with that prefix removed. There is no back-pressure on the outputs: reservation-station capacity arrives through `rs_avail`.

Top module: `bundle_issue_ctrl`

## Requirements
- R1: In one bundle at most one lane of each class issues. Class codes are 0 integer, 1 floating point, 2 load, 3 store. The second lane of a class already issued in the bundle is blocked.
- R2: Issue is in program order. The first lane that cannot issue blocks every younger lane. Lanes after the first invalid lane are not issued. Nothing issues while `bnd_valid` is low.
- R3: A lane whose class bit in `rs_avail` is low (bit index equals class code) is blocked.
- R4: The issued lane k receives tag (tail + k) mod `ROB_DEPTH`. The tail advances by `issue_cnt` each cycle and wraps.
- R5: Lane k issues only if more than k reorder-buffer entries are free. Free entries equal `ROB_DEPTH` minus occupancy. An entry freed by a retire becomes usable in the following cycle.
- R6: A source that matches the destination of an older writing lane in the same bundle takes the tag of the nearest such lane and is not ready.
- R7: Otherwise a source whose register is mapped in the status table takes the mapped tag and is not ready. An unmapped source is ready.
- R8: After issue, each written register maps to the tag of the youngest issued lane that writes it.
- R9: `retire_en` frees the head entry when the buffer is not empty. In the same cycle it clears any register mapping that points to that tag, unless an issued lane writes that register in that cycle.
- R10: `bnd_ready` is high exactly when `bnd_valid` is high and every lane before the first invalid lane has issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_valid | input | 1 | Bundle present |
| bnd_ready | output | 1 | Whole bundle consumed this cycle |
| lane_vld | input | LANES | Per-lane instruction present |
| lane_cls | input | 2*LANES | Per-lane class code |
| lane_dst_en | input | LANES | Lane writes a destination |
| lane_dst | input | AREGW*LANES | Destination register per lane |
| lane_src1 | input | AREGW*LANES | First source register per lane |
| lane_src2 | input | AREGW*LANES | Second source register per lane |
| rs_avail | input | 4 | Per-class station has a free slot |
| retire_en | input | 1 | Free the oldest reorder-buffer entry |
| issue_mask | output | LANES | Lanes issued this cycle (a prefix) |
| issue_cnt | output | CNTW | Number of lanes issued |
| lane_tag | output | TAGW*LANES | New reorder-buffer tag per lane |
| src1_tag | output | TAGW*LANES | Producer tag of first source |
| src1_rdy | output | LANES | First source has no in-flight producer |
| src2_tag | output | TAGW*LANES | Producer tag of second source |
| src2_rdy | output | LANES | Second source has no in-flight producer |

## Verification
The hardest situation to reach is a full reorder buffer combined with a retire in the same cycle, where the buffer pointers have also wrapped. To get there, the stimulus first issues a run of dependent bundles and retires a few entries. It then presents full four-class bundles until the free count drops to two, then to zero. At zero it strobes retire together with a bundle. This checks that the freed entry becomes usable one cycle later and that tags wrap past the top of the buffer. The cases where several lanes write the same register are reached with hand-built bundles in which one register is written twice and read by later lanes.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int NUM_CLS = 4;
  localparam int CLSW    = 2;
  typedef enum logic [CLSW-1:0] {
    CLS_INT   = 2'd0,
    CLS_FP    = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } op_cls_e;
endpackage

// File: rtl/bdc_issue_select.sv
module bdc_issue_select #(
  parameter int LANES = 4,
  parameter int CNTW  = 3,
  parameter int FREEW = 5
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       bnd_valid,
  input  logic [LANES-1:0]                           lane_vld,
  input  logic [LANES-1:0][bdc_pkg::CLSW-1:0]        lane_cls,
  input  logic [bdc_pkg::NUM_CLS-1:0]                rs_avail,
  input  logic [FREEW-1:0]                           rob_free,
  output logic [LANES-1:0]                           issue_mask,
  output logic [CNTW-1:0]                            issue_cnt,
  output logic                                       bundle_done
);
  logic [LANES:0] go;
  assign go[0] = bnd_valid;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic clash;
      always_comb begin
        clash = 1'b0;
        for (int j = 0; j < i; j++)
          if (lane_cls[j] == lane_cls[i]) clash = 1'b1;
      end
      assign issue_mask[i] = go[i] & lane_vld[i] & rs_avail[lane_cls[i]]
                             & ~clash & (rob_free > FREEW'(i));
      assign go[i+1] = issue_mask[i];
    end
  endgenerate

  logic [CNTW-1:0] lead;
  always_comb begin
    logic gap;
    gap       = 1'b0;
    lead      = '0;
    issue_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      issue_cnt = issue_cnt + CNTW'(issue_mask[i]);
      if (!lane_vld[i]) gap = 1'b1;
      else if (!gap)    lead = lead + 1'b1;
    end
  end
  assign bundle_done = bnd_valid & (issue_cnt == lead);

  generate
    for (genvar c = 0; c < bdc_pkg::NUM_CLS; c++) begin : g_cls_chk
      logic [LANES-1:0] hit;
      always_comb
        for (int i = 0; i < LANES; i++)
          hit[i] = issue_mask[i] & (lane_cls[i] == bdc_pkg::CLSW'(c));
      AST_ONE_PER_CLASS: assert property (@(posedge clk) disable iff (!rst_n) $countones(hit) <= 1); // R1
    end
  endgenerate

  logic [LANES:0] mask_ext;
  assign mask_ext = {1'b0, issue_mask};
  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n) ((mask_ext + 1'b1) & mask_ext) == '0); // R2
  AST_ROB_ROOM: assert property (@(posedge clk) disable iff (!rst_n) $countones(issue_mask) <= int'(rob_free)); // R5
endmodule

// File: rtl/bdc_rob_alloc.sv
module bdc_rob_alloc #(
  parameter int DEPTH = 16,
  parameter int TAGW  = 4,
  parameter int CNTW  = 3,
  parameter int FREEW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNTW-1:0]  issue_cnt,
  input  logic             retire_en,
  output logic [TAGW-1:0]  tail,
  output logic [TAGW-1:0]  head,
  output logic [FREEW-1:0] rob_free,
  output logic             pop
);
  logic [FREEW-1:0] occ;

  assign pop      = retire_en & (occ != '0);
  assign rob_free = FREEW'(DEPTH) - occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
      head <= '0;
      occ  <= '0;
    end else begin
      tail <= tail + TAGW'(issue_cnt);
      head <= head + TAGW'(pop);
      occ  <= occ + FREEW'(issue_cnt) - FREEW'(pop);
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= FREEW'(DEPTH)); // R5
  AST_PTR_MEET: assert property (@(posedge clk) disable iff (!rst_n) (occ == '0 || occ == FREEW'(DEPTH)) |-> head == tail); // R4
endmodule

// File: rtl/bdc_reg_status.sv
module bdc_reg_status #(
  parameter int NREG  = 32,
  parameter int AREGW = 5,
  parameter int TAGW  = 4,
  parameter int LANES = 4,
  parameter int NRD   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NRD-1:0][AREGW-1:0]    rd_addr,
  output logic [NRD-1:0]               rd_busy,
  output logic [NRD-1:0][TAGW-1:0]     rd_tag,
  input  logic [LANES-1:0]             wr_en,
  input  logic [LANES-1:0][AREGW-1:0]  wr_addr,
  input  logic [LANES-1:0][TAGW-1:0]   wr_tag,
  input  logic                         clr_en,
  input  logic [TAGW-1:0]              clr_tag
);
  logic [NREG-1:0]           busy;
  logic [NREG-1:0][TAGW-1:0] tags;

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_busy[k] = busy[rd_addr[k]];
      assign rd_tag[k]  = tags[rd_addr[k]];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      tags <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (clr_en && busy[r] && tags[r] == clr_tag) busy[r] <= 1'b0;
        for (int i = 0; i < LANES; i++)
          if (wr_en[i] && wr_addr[i] == AREGW'(r)) begin
            busy[r] <= 1'b1;
            tags[r] <= wr_tag[i];
          end
      end
    end
  end

  AST_YOUNGEST_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[LANES-1] |=> busy[$past(wr_addr[LANES-1])] && tags[$past(wr_addr[LANES-1])] == $past(wr_tag[LANES-1])); // R8
endmodule

// File: rtl/bdc_dep_resolve.sv
module bdc_dep_resolve #(
  parameter int LANES = 4,
  parameter int AREGW = 5,
  parameter int TAGW  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             dst_en,
  input  logic [LANES-1:0][AREGW-1:0]  dst,
  input  logic [LANES-1:0][AREGW-1:0]  src1,
  input  logic [LANES-1:0][AREGW-1:0]  src2,
  input  logic [TAGW-1:0]              tail,
  input  logic [LANES-1:0]             map_busy1,
  input  logic [LANES-1:0][TAGW-1:0]   map_tag1,
  input  logic [LANES-1:0]             map_busy2,
  input  logic [LANES-1:0][TAGW-1:0]   map_tag2,
  output logic [LANES-1:0][TAGW-1:0]   lane_tag,
  output logic [LANES-1:0][TAGW-1:0]   s1_tag,
  output logic [LANES-1:0]             s1_rdy,
  output logic [LANES-1:0][TAGW-1:0]   s2_tag,
  output logic [LANES-1:0]             s2_rdy
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_tag[i] = tail + TAGW'(i);

      logic            pend1, pend2;
      logic [TAGW-1:0] tg1, tg2;
      always_comb begin
        pend1 = map_busy1[i];
        tg1   = map_tag1[i];
        pend2 = map_busy2[i];
        tg2   = map_tag2[i];
        for (int j = 0; j < i; j++) begin
          if (dst_en[j] && dst[j] == src1[i]) begin
            pend1 = 1'b1;
            tg1   = lane_tag[j];
          end
          if (dst_en[j] && dst[j] == src2[i]) begin
            pend2 = 1'b1;
            tg2   = lane_tag[j];
          end
        end
      end
      assign s1_rdy[i] = ~pend1;
      assign s1_tag[i] = pend1 ? tg1 : '0;
      assign s2_rdy[i] = ~pend2;
      assign s2_tag[i] = pend2 ? tg2 : '0;

      if (i > 0) begin : g_chk
        AST_NEAREST_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
          (dst_en[i-1] && dst[i-1] == src1[i]) |-> (!s1_rdy[i] && s1_tag[i] == lane_tag[i-1])); // R6
      end
    end
  endgenerate
endmodule

// File: rtl/bundle_issue_ctrl.sv
module bundle_issue_ctrl #(
  parameter int LANES     = 4,
  parameter int NREG      = 32,
  parameter int ROB_DEPTH = 16,
  localparam int AREGW    = $clog2(NREG),
  localparam int TAGW     = $clog2(ROB_DEPTH),
  localparam int CNTW     = $clog2(LANES + 1),
  localparam int FREEW    = $clog2(ROB_DEPTH + 1)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bnd_valid,
  output logic                                   bnd_ready,
  input  logic [LANES-1:0]                       lane_vld,
  input  logic [bdc_pkg::CLSW*LANES-1:0]         lane_cls,
  input  logic [LANES-1:0]                       lane_dst_en,
  input  logic [AREGW*LANES-1:0]                 lane_dst,
  input  logic [AREGW*LANES-1:0]                 lane_src1,
  input  logic [AREGW*LANES-1:0]                 lane_src2,
  input  logic [bdc_pkg::NUM_CLS-1:0]            rs_avail,
  input  logic                                   retire_en,
  output logic [LANES-1:0]                       issue_mask,
  output logic [CNTW-1:0]                        issue_cnt,
  output logic [TAGW*LANES-1:0]                  lane_tag,
  output logic [TAGW*LANES-1:0]                  src1_tag,
  output logic [LANES-1:0]                       src1_rdy,
  output logic [TAGW*LANES-1:0]                  src2_tag,
  output logic [LANES-1:0]                       src2_rdy
);
  logic [LANES-1:0][bdc_pkg::CLSW-1:0] cls_p;
  logic [LANES-1:0][AREGW-1:0]         dst_p, s1_p, s2_p;
  logic [LANES-1:0][TAGW-1:0]          ltag_p, s1t_p, s2t_p;
  logic [2*LANES-1:0][AREGW-1:0]       rd_addr;
  logic [2*LANES-1:0]                  rd_busy;
  logic [2*LANES-1:0][TAGW-1:0]        rd_tag;
  logic [LANES-1:0]                    mb1, mb2;
  logic [LANES-1:0][TAGW-1:0]          mt1, mt2;
  logic [TAGW-1:0]                     tail, head;
  logic [FREEW-1:0]                    rob_free;
  logic                                pop;

  assign cls_p = lane_cls;
  assign dst_p = lane_dst;
  assign s1_p  = lane_src1;
  assign s2_p  = lane_src2;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_map
      assign rd_addr[2*i]   = s1_p[i];
      assign rd_addr[2*i+1] = s2_p[i];
      assign mb1[i] = rd_busy[2*i];
      assign mt1[i] = rd_tag[2*i];
      assign mb2[i] = rd_busy[2*i+1];
      assign mt2[i] = rd_tag[2*i+1];
    end
  endgenerate

  bdc_issue_select #(.LANES(LANES), .CNTW(CNTW), .FREEW(FREEW)) u_sel (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .lane_vld(lane_vld),
    .lane_cls(cls_p), .rs_avail(rs_avail), .rob_free(rob_free),
    .issue_mask(issue_mask), .issue_cnt(issue_cnt), .bundle_done(bnd_ready)
  );

  bdc_rob_alloc #(.DEPTH(ROB_DEPTH), .TAGW(TAGW), .CNTW(CNTW), .FREEW(FREEW)) u_rob (
    .clk(clk), .rst_n(rst_n), .issue_cnt(issue_cnt), .retire_en(retire_en),
    .tail(tail), .head(head), .rob_free(rob_free), .pop(pop)
  );

  bdc_reg_status #(.NREG(NREG), .AREGW(AREGW), .TAGW(TAGW), .LANES(LANES), .NRD(2*LANES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_busy(rd_busy), .rd_tag(rd_tag),
    .wr_en(issue_mask & lane_dst_en), .wr_addr(dst_p), .wr_tag(ltag_p),
    .clr_en(pop), .clr_tag(head)
  );

  bdc_dep_resolve #(.LANES(LANES), .AREGW(AREGW), .TAGW(TAGW)) u_dep (
    .clk(clk), .rst_n(rst_n), .dst_en(lane_dst_en), .dst(dst_p),
    .src1(s1_p), .src2(s2_p), .tail(tail),
    .map_busy1(mb1), .map_tag1(mt1), .map_busy2(mb2), .map_tag2(mt2),
    .lane_tag(ltag_p), .s1_tag(s1t_p), .s1_rdy(src1_rdy),
    .s2_tag(s2t_p), .s2_rdy(src2_rdy)
  );

  assign lane_tag = ltag_p;
  assign src1_tag = s1t_p;
  assign src2_tag = s2t_p;

  AST_READY_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_ready && lane_vld[0]) |-> issue_mask[0]); // R10
endmodule

// File: tb/test_bundle_issue_ctrl.sv
`timescale 1ns/1ps
module test_bundle_issue_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_valid, bnd_ready, retire_en;
  logic [3:0]  lane_vld, lane_dst_en, rs_avail, issue_mask, src1_rdy, src2_rdy;
  logic [7:0]  lane_cls;
  logic [19:0] lane_dst, lane_src1, lane_src2;
  logic [2:0]  issue_cnt;
  logic [15:0] lane_tag, src1_tag, src2_tag;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bundle_issue_ctrl i_bundle_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
    .lane_vld(lane_vld), .lane_cls(lane_cls), .lane_dst_en(lane_dst_en),
    .lane_dst(lane_dst), .lane_src1(lane_src1), .lane_src2(lane_src2),
    .rs_avail(rs_avail), .retire_en(retire_en), .issue_mask(issue_mask),
    .issue_cnt(issue_cnt), .lane_tag(lane_tag), .src1_tag(src1_tag),
    .src1_rdy(src1_rdy), .src2_tag(src2_tag), .src2_rdy(src2_rdy)
  );

  typedef struct packed {
    logic [3:0]  vld;
    logic [7:0]  cls;
    logic [3:0]  den;
    logic [19:0] dst;
    logic [19:0] s1;
    logic [19:0] s2;
    logic [3:0]  rs;
    logic [3:0]  emask;
    logic [3:0]  ebase;
    logic [15:0] et1;
    logic [3:0]  er1;
    logic [15:0] et2;
    logic [3:0]  er2;
    logic        erdy;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'hF, {2'd3,2'd2,2'd1,2'd0}, 4'b0111, {5'd0,5'd1,5'd4,5'd1}, {5'd1,5'd4,5'd1,5'd2},
      {5'd6,5'd0,5'd5,5'd3}, 4'hF, 4'hF, 4'd0, {4'd2,4'd1,4'd0,4'd0}, 4'b0001, 16'h0, 4'b1111, 1'b1},
    '{4'b0111, {2'd0,2'd1,2'd0,2'd0}, 4'b0011, {5'd0,5'd0,5'd3,5'd2}, {5'd0,5'd0,5'd0,5'd1},
      {5'd0,5'd0,5'd0,5'd4}, 4'hF, 4'b0001, 4'd4, {12'h0,4'd2}, 4'b0000, {12'h0,4'd1}, 4'b0000, 1'b0},
    '{4'b0011, {2'd0,2'd0,2'd1,2'd2}, 4'b0011, {5'd0,5'd0,5'd6,5'd5}, {5'd0,5'd0,5'd0,5'd2},
      {5'd0,5'd0,5'd0,5'd9}, 4'b1101, 4'b0001, 4'd5, {12'h0,4'd4}, 4'b0000, 16'h0, 4'b0001, 1'b0},
    '{4'b0010, 8'h0, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 4'h0, 4'd6, 16'h0, 4'h0, 16'h0, 4'h0, 1'b1},
    '{4'hF, {2'd3,2'd2,2'd1,2'd0}, 4'b0111, {5'd0,5'd8,5'd7,5'd7}, {5'd7,5'd7,5'd7,5'd0},
      {5'd8,5'd5,5'd7,5'd0}, 4'hF, 4'hF, 4'd6, {4'd7,4'd7,4'd6,4'd0}, 4'b0001, {4'd8,4'd5,4'd6,4'd0}, 4'b0001, 1'b1},
    '{4'b0001, 8'h0, 4'b0001, {15'h0,5'd9}, {15'h0,5'd7}, {15'h0,5'd1}, 4'hF, 4'b0001, 4'd10,
      {12'h0,4'd7}, 4'b0000, {12'h0,4'd2}, 4'b0000, 1'b1}
  };

  function automatic string vec_req(int k);
    case (k)
      0: return "R4 R6 R7";
      1: return "R1";
      2: return "R3";
      3: return "R2";
      4: return "R6 R8";
      default: return "R7 R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic bv, logic [3:0] vld, logic [7:0] cls, logic [3:0] den,
                       logic [19:0] dst, logic [19:0] s1, logic [19:0] s2,
                       logic [3:0] rs, logic ret);
    @(negedge clk);
    bnd_valid = bv; lane_vld = vld; lane_cls = cls; lane_dst_en = den;
    lane_dst = dst; lane_src1 = s1; lane_src2 = s2; rs_avail = rs; retire_en = ret;
    #1;
  endtask

  localparam logic [7:0] ALLCLS = {2'd3,2'd2,2'd1,2'd0};

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bnd_valid = 0; lane_vld = 0; lane_cls = 0; lane_dst_en = 0; lane_dst = 0;
    lane_src1 = 0; lane_src2 = 0; rs_avail = 4'hF; retire_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2: bundle not valid issues nothing after reset
    drive(1'b0, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    chk("R2 idle mask", 32'(issue_mask), 32'h0);
    chk("R10 idle ready", 32'(bnd_ready), 32'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      drive(1'b1, v.vld, v.cls, v.den, v.dst, v.s1, v.s2, v.rs, 1'b0);
      chk({vec_req(k), " R2 mask"}, 32'(issue_mask), 32'(v.emask));
      chk("R10 ready", 32'(bnd_ready), 32'(v.erdy));
      chk("R2 count", 32'(issue_cnt), 32'($countones(v.emask)));
      for (int i = 0; i < 4; i++) begin
        if (v.emask[i]) begin
          chk("R4 lane tag", 32'(lane_tag[4*i +: 4]), 32'(4'(v.ebase + 4'(i))));
          chk({vec_req(k), " src1 ready"}, 32'(src1_rdy[i]), 32'(v.er1[i]));
          chk({vec_req(k), " src2 ready"}, 32'(src2_rdy[i]), 32'(v.er2[i]));
          if (!v.er1[i]) chk({vec_req(k), " src1 tag"}, 32'(src1_tag[4*i +: 4]), 32'(v.et1[4*i +: 4]));
          if (!v.er2[i]) chk({vec_req(k), " src2 tag"}, 32'(src2_tag[4*i +: 4]), 32'(v.et2[4*i +: 4]));
        end
      end
    end

    // R9: two retires free tags 0 and 1; r4 was mapped to tag 1
    drive(1'b0, 4'h0, 8'h0, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b1);
    drive(1'b0, 4'h0, 8'h0, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b1);
    drive(1'b1, 4'b0001, 8'h0, 4'b0001, {15'h0,5'd10}, {15'h0,5'd4}, {15'h0,5'd2}, 4'hF, 1'b0);
    chk("R9 cleared src ready", 32'(src1_rdy[0]), 32'h1);
    chk("R7 mapped src not ready", 32'(src2_rdy[0]), 32'h0);
    chk("R7 mapped src tag", 32'(src2_tag[3:0]), 32'd4);
    chk("R4 tag after retire", 32'(lane_tag[3:0]), 32'd11);

    // R5: fill the reorder buffer (10 in flight, 6 free)
    drive(1'b1, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    chk("R5 four fit", 32'(issue_cnt), 32'd4);
    chk("R4 base 12", 32'(lane_tag[3:0]), 32'd12);
    drive(1'b1, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    chk("R5 two free", 32'(issue_mask), 32'b0011);
    chk("R4 wrap tag", 32'(lane_tag[7:4]), 32'd1);
    chk("R10 partial", 32'(bnd_ready), 32'h0);
    drive(1'b1, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    chk("R5 full", 32'(issue_cnt), 32'd0);
    drive(1'b1, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b1);
    chk("R5 retire same cycle", 32'(issue_cnt), 32'd0);
    drive(1'b1, 4'hF, ALLCLS, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    chk("R5 freed next cycle", 32'(issue_mask), 32'b0001);
    chk("R4 reused tag", 32'(lane_tag[3:0]), 32'd2);

    drive(1'b0, 4'h0, 8'h0, 4'h0, 20'h0, 20'h0, 20'h0, 4'hF, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule